// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port shared memory. It watches the chip enable and the word address of each port. When both ports are enabled on the same word at once, it decides which port may go ahead and raises a busy flag towards the other port. Each port's write strobe passes through the block. It comes out as a gated write enable that is held low for as long as that port's busy flag is up. The storage array, the analog timing and the pads belong elsewhere. Everything here is synchronous, and all time is counted in clock cycles.

A static mode input selects master or slave behaviour. A master computes busy from its own arbitration. A slave does no arbitration of its own: it takes busy from external inputs, which are normally wired to a master's busy outputs. Several memory slices can then share one decision and act as a single wider word.

The arbiter judges arrival by history. A port whose enable and address are unchanged since the previous cycle got there first, and it beats a port that has just enabled or moved. When both ports arrive in the same cycle, the left port wins. The winner keeps its grant until it drops its enable or changes its address.

Top module: `dp_contention_arbiter`

## Requirements
- R1: In master mode, if in a cycle the two chip enables are not both high or the two addresses differ, then both busy outputs are low in the following cycle.
- R2: In master mode, if in a cycle both chip enables are high and the addresses are equal, then in the following cycle exactly one busy output is high.
- R3: A port counts as "held" in a cycle when its chip enable was high in the previous cycle and its address is the same as in the previous cycle. If contention begins and neither port is held, or both are, the left port wins and the right busy goes high.
- R4: If contention begins while only one port is held, the held port wins and the other port's busy goes high. This covers both an address change that creates the match and a chip enable that goes high onto an address that already matches.
- R5: While contention continues and the current winner stays held, the winner keeps its grant. The busy flags stay as they are even when the losing port changes its inputs.
- R6: If the current winner is not held while contention continues, the grant is decided again by the rules of R3 and R4.
- R7: In slave mode (mode input low), each busy output equals that port's external busy input from the previous cycle, and no internal arbitration takes place.
- R8: Each port's gated write enable equals its write strobe AND NOT its busy output, in the same cycle, in both modes.
- R9: During reset and in the first cycle after reset, both busy outputs are low and each gated write enable follows its write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1 = master (busy computed here), 0 = slave (busy taken from inputs) |
| l_ce | input | 1 | Left port chip enable, active high |
| l_addr | input | ADDR_W | Left port word address |
| l_we | input | 1 | Left port write strobe, active high |
| r_ce | input | 1 | Right port chip enable, active high |
| r_addr | input | ADDR_W | Right port word address |
| r_we | input | 1 | Right port write strobe, active high |
| l_busy_in | input | 1 | External busy for the left port, used in slave mode |
| r_busy_in | input | 1 | External busy for the right port, used in slave mode |
| l_busy | output | 1 | Left port busy flag, registered |
| r_busy | output | 1 | Right port busy flag, registered |
| l_we_gated | output | 1 | Left write enable after suppression by busy |
| r_we_gated | output | 1 | Right write enable after suppression by busy |

## Verification
The bench builds the arbiter with ADDR_W = 3. With only eight words, random addresses from the two ports collide often. Random traffic therefore reaches fresh ties, late arrivals, held grants and re-arbitration after a winner moves. Directed sequences run first and pin down the left-first tie, a chip enable arriving onto an address that already matches, the loser's busy clearing after the winner leaves, and slave mode following the external busy inputs.

// File: rtl/dp_arb_pkg.sv
// Package: shared types for the dual-port contention arbiter.
// Assumes two ports only; index 0 is the left port, index 1 the right.
package dp_arb_pkg;

    // Which port currently holds the grant on a contended word.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    localparam int PORT_L  = 0;
    localparam int PORT_R  = 1;
    localparam int N_PORTS = 2;

endpackage

// File: rtl/dp_addr_match.sv
// Module: dp_addr_match
// Detects contention between the two ports and tells whether each port is
// "held": its enable was high last cycle and its address has not moved.
// Assumes addresses are stable within a cycle; match is combinational.
module dp_addr_match #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_ce,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              match,
    output logic              l_held,
    output logic              r_held
);

    logic              l_ce_q;
    logic              r_ce_q;
    logic [ADDR_W-1:0] l_addr_q;
    logic [ADDR_W-1:0] r_addr_q;

    // Remember last cycle's enable and address of both ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_ce_q   <= 1'b0;
            r_ce_q   <= 1'b0;
            l_addr_q <= '0;
            r_addr_q <= '0;
        end else begin
            l_ce_q   <= l_ce;
            r_ce_q   <= r_ce;
            l_addr_q <= l_addr;
            r_addr_q <= r_addr;
        end
    end

    // Contention and per-port arrival history for the current cycle.
    always_comb begin
        match  = l_ce && r_ce && (l_addr == r_addr);
        l_held = l_ce && l_ce_q && (l_addr == l_addr_q);
        r_held = r_ce && r_ce_q && (r_addr == r_addr_q);
    end

endmodule

// File: rtl/dp_grant_fsm.sv
// Module: dp_grant_fsm
// Holds the current owner of a contended word and computes next cycle's
// owner. A held owner keeps its grant. A new contention goes to the sole
// held port, and otherwise to the left port. Slave mode forces no owner.
module dp_grant_fsm
    import dp_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   master_mode,
    input  logic   match,
    input  logic   l_held,
    input  logic   r_held,
    output owner_e owner_nxt
);

    owner_e owner_q;

    // Next owner from contention, current owner and arrival history.
    always_comb begin
        if (!master_mode || !match)
            owner_nxt = OWN_NONE;
        else if (owner_q == OWN_LEFT && l_held)
            owner_nxt = OWN_LEFT;
        else if (owner_q == OWN_RIGHT && r_held)
            owner_nxt = OWN_RIGHT;
        else if (r_held && !l_held)
            owner_nxt = OWN_RIGHT;
        else
            owner_nxt = OWN_LEFT;
    end

    // Owner register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            owner_q <= OWN_NONE;
        else
            owner_q <= owner_nxt;
    end

endmodule

// File: rtl/dp_busy_port.sv
// Module: dp_busy_port
// Per-port busy flag register and write gating. In master mode busy
// follows the arbiter's "lost" decision; in slave mode it registers the
// external busy input. The write strobe is gated by the registered busy.
module dp_busy_port (
    input  logic clk,
    input  logic rst_n,
    input  logic master_mode,
    input  logic lost_nxt,
    input  logic busy_ext,
    input  logic we,
    output logic busy,
    output logic we_gated
);

    // Busy register, source picked by mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else
            busy <= master_mode ? lost_nxt : busy_ext;
    end

    // Suppress the write while busy is active.
    always_comb begin
        we_gated = we && !busy;
    end

endmodule

// File: rtl/dp_contention_arbiter.sv
// Module: dp_contention_arbiter (top)
// Address contention arbiter for a two-port shared memory with a
// master/slave strap. Assumes master_mode is quasi-static and that all
// inputs are synchronous to clk.
module dp_contention_arbiter
    import dp_arb_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_ce,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_we,
    input  logic              r_ce,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_we,
    input  logic              l_busy_in,
    input  logic              r_busy_in,
    output logic              l_busy,
    output logic              r_busy,
    output logic              l_we_gated,
    output logic              r_we_gated
);

    logic               match;
    logic               l_held;
    logic               r_held;
    owner_e             owner_nxt;
    logic [N_PORTS-1:0] lost_v;
    logic [N_PORTS-1:0] ext_v;
    logic [N_PORTS-1:0] we_v;
    logic [N_PORTS-1:0] busy_v;
    logic [N_PORTS-1:0] weg_v;

    dp_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .l_ce   (l_ce),
        .l_addr (l_addr),
        .r_ce   (r_ce),
        .r_addr (r_addr),
        .match  (match),
        .l_held (l_held),
        .r_held (r_held)
    );

    dp_grant_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .match       (match),
        .l_held      (l_held),
        .r_held      (r_held),
        .owner_nxt   (owner_nxt)
    );

    // A port loses when the other port owns the word next cycle.
    always_comb begin
        lost_v[PORT_L] = (owner_nxt == OWN_RIGHT);
        lost_v[PORT_R] = (owner_nxt == OWN_LEFT);
        ext_v          = {r_busy_in, l_busy_in};
        we_v           = {r_we, l_we};
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        dp_busy_port u_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .master_mode (master_mode),
            .lost_nxt    (lost_v[p]),
            .busy_ext    (ext_v[p]),
            .we          (we_v[p]),
            .busy        (busy_v[p]),
            .we_gated    (weg_v[p])
        );
    end

    // Unpack per-port results onto the ports.
    always_comb begin
        l_busy     = busy_v[PORT_L];
        r_busy     = busy_v[PORT_R];
        l_we_gated = weg_v[PORT_L];
        r_we_gated = weg_v[PORT_R];
    end

endmodule

// File: rtl/dp_contention_arbiter_chk.sv
// Module: dp_contention_arbiter_chk
// Property checker for the arbiter, attached to the top by bind below.
module dp_contention_arbiter_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              l_ce,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_we,
    input logic              r_ce,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_we,
    input logic              l_busy_in,
    input logic              r_busy_in,
    input logic              l_busy,
    input logic              r_busy,
    input logic              l_we_gated,
    input logic              r_we_gated
);

    logic contend;
    assign contend = l_ce && r_ce && (l_addr == r_addr);

    // R1: no contention in master mode means no busy next cycle.
    assert_no_false_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !contend) |=> (!l_busy && !r_busy));

    // R2: contention in master mode gives exactly one busy next cycle.
    assert_one_loser_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && contend) |=> (l_busy != r_busy));

    // R7: slave mode registers the external busy inputs.
    assert_slave_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |=> (l_busy == $past(l_busy_in) && r_busy == $past(r_busy_in)));

    // R8: a busy port never sees its write enable.
    assert_left_write_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy |-> !l_we_gated);

    // R8: a busy port never sees its write enable (right side).
    assert_right_write_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_busy |-> !r_we_gated);

    // R8: a port that is not busy passes its strobe.
    assert_write_passes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy && l_we) |-> l_we_gated);

endmodule

bind dp_contention_arbiter dp_contention_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .l_ce        (l_ce),
    .l_addr      (l_addr),
    .l_we        (l_we),
    .r_ce        (r_ce),
    .r_addr      (r_addr),
    .r_we        (r_we),
    .l_busy_in   (l_busy_in),
    .r_busy_in   (r_busy_in),
    .l_busy      (l_busy),
    .r_busy      (r_busy),
    .l_we_gated  (l_we_gated),
    .r_we_gated  (r_we_gated)
);

// File: tb/tb_dp_contention_arbiter.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random traffic, compared
// against a cycle model built from the requirements.
module tb_dp_contention_arbiter;

    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_mode = 1'b1;
    logic          l_ce = 1'b0, r_ce = 1'b0, l_we = 1'b0, r_we = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_busy_in = 1'b0, r_busy_in = 1'b0;
    logic          l_busy, r_busy, l_we_gated, r_we_gated;

    int n_checks = 0;
    int n_fail   = 0;

    // Model state: previous inputs, owner (0 none, 1 left, 2 right), busy.
    logic          m_lce_q = 1'b0, m_rce_q = 1'b0;
    logic [AW-1:0] m_la_q = '0, m_ra_q = '0;
    int            m_owner = 0;
    logic          m_lb = 1'b0, m_rb = 1'b0;

    always #2.5 clk = ~clk;

    dp_contention_arbiter #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_ce(l_ce), .l_addr(l_addr), .l_we(l_we),
        .r_ce(r_ce), .r_addr(r_addr), .r_we(r_we),
        .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
        .l_busy(l_busy), .r_busy(r_busy),
        .l_we_gated(l_we_gated), .r_we_gated(r_we_gated)
    );

    // Next owner per R1, R3, R4, R5, R6.
    function automatic int next_owner(input int own, input logic mm,
                                      input logic mt, input logic lh, input logic rh);
        if (!mm || !mt)            return 0;
        if (own == 1 && lh)        return 1;
        if (own == 2 && rh)        return 2;
        if (rh && !lh)             return 2;
        return 1;
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {lb,rb,lweg,rweg} actual %b expected %b", tag, act, exp);
        end
    endtask

    // Model update at a clock edge, using inputs as they stand.
    task automatic model_edge();
        logic mt, lh, rh;
        int   nx;
        if (!rst_n) begin
            m_lce_q = 0; m_rce_q = 0; m_la_q = '0; m_ra_q = '0;
            m_owner = 0; m_lb = 0; m_rb = 0;
        end else begin
            mt = l_ce && r_ce && (l_addr == r_addr);
            lh = l_ce && m_lce_q && (l_addr == m_la_q);
            rh = r_ce && m_rce_q && (r_addr == m_ra_q);
            nx = next_owner(m_owner, master_mode, mt, lh, rh);
            m_lb = master_mode ? (nx == 2) : l_busy_in;
            m_rb = master_mode ? (nx == 1) : r_busy_in;
            m_owner = nx;
            m_lce_q = l_ce; m_rce_q = r_ce; m_la_q = l_addr; m_ra_q = r_addr;
        end
    endtask

    // Apply one cycle of inputs at a falling edge and check after the next edge.
    task automatic step(input string tag, input logic mm,
                        input logic lc, input logic [AW-1:0] la, input logic lw,
                        input logic rc, input logic [AW-1:0] ra, input logic rw,
                        input logic lbi, input logic rbi);
        master_mode = mm;
        l_ce = lc; l_addr = la; l_we = lw;
        r_ce = rc; r_addr = ra; r_we = rw;
        l_busy_in = lbi; r_busy_in = rbi;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, {l_busy, r_busy, l_we_gated, r_we_gated},
              {m_lb, m_rb, l_we && !m_lb, r_we && !m_rb});
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        logic mm;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        @(negedge clk);
        // R9: reset state with strobes active and contention present.
        rst_n = 0;
        step("R9 in reset", 1, 1, 3'd2, 1, 1, 3'd2, 1, 0, 0);
        rst_n = 1;
        step("R9 first cycle after reset", 1, 0, 3'd0, 1, 0, 3'd0, 1, 0, 0);
        check("R9 busy low after reset", {l_busy, r_busy}, 2'b00);

        // R3: both arrive on word 4 in one cycle, left wins.
        step("R3 tie", 1, 1, 3'd4, 1, 1, 3'd4, 1, 0, 0);
        check("R3 right busy on tie", {l_busy, r_busy, r_we_gated}, 3'b010);
        // R5: hold for a few cycles; right wanders and comes back.
        step("R5 hold", 1, 1, 3'd4, 1, 1, 3'd4, 1, 0, 0);
        step("R5 hold loser moves", 1, 1, 3'd4, 0, 1, 3'd1, 1, 0, 0);
        step("R4 loser returns", 1, 1, 3'd4, 0, 1, 3'd4, 1, 0, 0);
        check("R4 held left beats returning right", {l_busy, r_busy}, 2'b01);
        // R6: winner moves onto nothing, loser busy clears next cycle.
        step("R6 winner leaves", 1, 1, 3'd6, 1, 1, 3'd4, 1, 0, 0);
        check("R6 busy cleared", {l_busy, r_busy}, 2'b00);
        // R4: left moves onto right's held word, right wins.
        step("R4 left moves in", 1, 1, 3'd4, 1, 1, 3'd4, 1, 0, 0);
        check("R4 right holds", {l_busy, r_busy, l_we_gated}, 3'b100);
        // R6: right winner moves, left follows in the same cycle: re-arbitrated tie.
        step("R6 both move", 1, 1, 3'd7, 1, 1, 3'd7, 0, 0, 0);
        check("R6 re-arbitration tie goes left", {l_busy, r_busy}, 2'b01);
        // R4: chip enable activation onto a matching address.
        step("R1 right off", 1, 1, 3'd2, 0, 0, 3'd2, 0, 0, 0);
        step("R4 right ce rises", 1, 1, 3'd2, 0, 1, 3'd2, 1, 0, 0);
        check("R4 ce arrival loses", {l_busy, r_busy}, 2'b01);
        step("R1 left off", 1, 0, 3'd2, 0, 1, 3'd2, 0, 0, 0);
        step("R4 left ce rises", 1, 1, 3'd2, 1, 1, 3'd2, 0, 0, 0);
        check("R4 left ce arrival loses", {l_busy, r_busy, l_we_gated}, 3'b100);
        // R1: different addresses never busy.
        step("R1 no match", 1, 1, 3'd1, 1, 1, 3'd0, 1, 0, 0);
        // R7: slave mode follows external inputs, ignores contention.
        step("R7 slave ext 10", 0, 1, 3'd5, 1, 1, 3'd5, 1, 1, 0);
        check("R7 left busy from input", {l_busy, r_busy, l_we_gated, r_we_gated}, 4'b1001);
        step("R7 slave ext 01", 0, 1, 3'd5, 1, 1, 3'd5, 1, 0, 1);
        step("R7 slave ext 00 under contention", 0, 1, 3'd5, 1, 1, 3'd5, 1, 0, 0);
        check("R7 no internal arbitration", {l_busy, r_busy}, 2'b00);
        step("R7 slave ext 11", 0, 0, 3'd0, 1, 0, 3'd0, 1, 1, 1);

        // Random traffic, mostly master mode (R1..R8).
        for (int i = 0; i < 4000; i++) begin
            mm = ($urandom % 8) != 0;
            step(mm ? "R2 random master" : "R7 random slave", mm,
                 ($urandom % 4) != 0, AW'($urandom), 1'($urandom),
                 ($urandom % 4) != 0, AW'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule